// File: doc/BRIEF.md
# Exception Entry Vector Controller

This block works out where the processor goes when an exception is taken, and how the privileged state changes on the way in. A request lasts one cycle. It carries an exception kind, the program counter of the faulting instruction, a delay-slot flag, a TLB-refill flag and a coprocessor number. The block also reads the current privileged state on its inputs: exception level, error level, bootstrap-vector select, interrupt-vector select, kernel/supervisor/user mode, branch-delay flag, exception code, coprocessor field, saved exception PC, saved error PC and the exception base.

On the next clock edge the block registers the new program counter and the updated copy of every state field. The surrounding core writes these values back into its own registers. Between requests the outputs keep their last values. A kind the block does not recognise changes nothing and raises a one-cycle error flag.

The 5-bit kind is the architectural exception code for ordinary exceptions. Three unused code points carry the special entries: 16 is a non-maskable interrupt, 17 is a soft reset and 19 is a debug exception.

Top module: `exc_vector_unit`

## Requirements
- R1: While reset is held, and afterwards until the first request, the outputs read as follows: next PC 0xBFC00000, error level 1, bootstrap select 1, all other state fields 0, done 0, error 0.
- R2: For an ordinary exception, the vector base is 0xBFC00200 when the bootstrap select (bev_i) is 1. When it is 0, the base is ebase_i with bits 9..0 forced to zero. The next PC is the base plus the offset.
- R3: An ordinary exception uses offset 0x180. The exception is an interrupt when the kind is 0, and an interrupt with iv_i = 1 uses offset 0x200 instead.
- R4: A TLB load (kind 2) or TLB store (kind 3) with refill_i = 1 and exl_i = 0 uses offset 0x000. When exl_i = 1 it uses 0x180.
- R5: A cache error (kind 30) uses offset 0x100 when bev_i = 1 and 0x20000100 when bev_i = 0.
- R6: The ordinary kinds are 0 to 13, 15 and 30. For these kinds exccode_o takes the kind value.
- R7: For an ordinary exception with exl_i = 0, the block updates four fields. epc_o becomes pc_i − 4 with bd_o = 1 when dslot_i = 1, and pc_i with bd_o = 0 otherwise. exl_o becomes 1, and ksu_o becomes 0 (kernel). With exl_i = 1, epc_o, bd_o and ksu_o copy their inputs and exl_o stays 1.
- R8: A coprocessor-unusable exception (kind 11) loads cop_i into ce_o. Every other ordinary kind passes ce_i through.
- R9: A non-maskable interrupt (kind 16) or a soft reset (kind 17) makes these changes. errepc_o becomes pc_i − 4 when dslot_i = 1 and pc_i otherwise. erl_o and bev_o become 1, ksu_o becomes 0, and the next PC is 0xBFC00000. exccode_o, epc_o, exl_o, bd_o and ce_o copy their inputs.
- R10: A debug exception (kind 19) sets the next PC to 0xBFC00480 and ksu_o to 0. Every other field copies its input.
- R11: Every output changes only on the clock edge after a request and holds its value while req_i is 0. done_o is 1 for exactly the cycle after an accepted request.
- R12: Any kind not listed in R6, R9 or R10 leaves every state output and the next PC unchanged. It raises err_o, not done_o, for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | One-cycle exception request |
| kind_i | input | 5 | Exception kind |
| pc_i | input | 32 | PC of the faulting instruction |
| dslot_i | input | 1 | Fault was in a branch delay slot |
| refill_i | input | 1 | TLB fault was a missing entry |
| cop_i | input | 2 | Coprocessor number for coprocessor-unusable |
| exl_i | input | 1 | Current exception level |
| erl_i | input | 1 | Current error level |
| bev_i | input | 1 | Current bootstrap-vector select |
| iv_i | input | 1 | Interrupt uses its own vector |
| ksu_i | input | 2 | Current mode (0 = kernel) |
| bd_i | input | 1 | Current branch-delay flag |
| exccode_i | input | 5 | Current exception code |
| ce_i | input | 2 | Current coprocessor field |
| epc_i | input | 32 | Current exception PC |
| errepc_i | input | 32 | Current error PC |
| ebase_i | input | 32 | Exception base |
| pc_o | output | 32 | Next program counter |
| exl_o | output | 1 | Updated exception level |
| erl_o | output | 1 | Updated error level |
| bev_o | output | 1 | Updated bootstrap select |
| ksu_o | output | 2 | Updated mode |
| bd_o | output | 1 | Updated branch-delay flag |
| exccode_o | output | 5 | Updated exception code |
| ce_o | output | 2 | Updated coprocessor field |
| epc_o | output | 32 | Updated exception PC |
| errepc_o | output | 32 | Updated error PC |
| done_o | output | 1 | Request accepted last edge |
| err_o | output | 1 | Unknown kind seen last edge |

## Verification
The bench goes after the cases where the vector offset depends on state as well as kind. One is a refill fault taken while EXL is already set: a design that ignores EXL would send it to offset 0 and lose the nested handler. Others are an interrupt with IV set, and a cache error with both BEV values; a block that shared the plain offset there would land in the general handler. Faults from a delay slot, with EXL clear and with EXL set, check that EPC and BD move only at the first level and are then corrected by four. The unused code points 14, 18 and 20 to 29, 31 must leave the state untouched, so a decoder that sent them down the default path would overwrite EPC.

// File: rtl/exc_vector_unit.sv
module exc_vector_unit #(
  parameter logic [31:0] BOOT_VEC   = 32'hBFC00000,
  parameter logic [31:0] BEV_BASE   = 32'hBFC00200,
  parameter logic [31:0] DEBUG_VEC  = 32'hBFC00480,
  parameter int          BASE_ALIGN = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_i,
  input  logic [4:0]  kind_i,
  input  logic [31:0] pc_i,
  input  logic        dslot_i,
  input  logic        refill_i,
  input  logic [1:0]  cop_i,
  input  logic        exl_i,
  input  logic        erl_i,
  input  logic        bev_i,
  input  logic        iv_i,
  input  logic [1:0]  ksu_i,
  input  logic        bd_i,
  input  logic [4:0]  exccode_i,
  input  logic [1:0]  ce_i,
  input  logic [31:0] epc_i,
  input  logic [31:0] errepc_i,
  input  logic [31:0] ebase_i,
  output logic [31:0] pc_o,
  output logic        exl_o,
  output logic        erl_o,
  output logic        bev_o,
  output logic [1:0]  ksu_o,
  output logic        bd_o,
  output logic [4:0]  exccode_o,
  output logic [1:0]  ce_o,
  output logic [31:0] epc_o,
  output logic [31:0] errepc_o,
  output logic        done_o,
  output logic        err_o
);
  localparam logic [4:0]  K_INT   = 5'd0;
  localparam logic [4:0]  K_TLBL  = 5'd2;
  localparam logic [4:0]  K_TLBS  = 5'd3;
  localparam logic [4:0]  K_COPU  = 5'd11;
  localparam logic [4:0]  K_FPE   = 5'd15;
  localparam logic [4:0]  K_NMI   = 5'd16;
  localparam logic [4:0]  K_SRST  = 5'd17;
  localparam logic [4:0]  K_DBG   = 5'd19;
  localparam logic [4:0]  K_CACHE = 5'd30;
  localparam logic [4:0]  K_LAST_LOW = 5'd13;
  localparam logic [31:0] OFF_GEN   = 32'h0000_0180;
  localparam logic [31:0] OFF_IRQ   = 32'h0000_0200;
  localparam logic [31:0] OFF_REFL  = 32'h0000_0000;
  localparam logic [31:0] OFF_CBEV  = 32'h0000_0100;
  localparam logic [31:0] OFF_CNORM = 32'h2000_0100;

  logic        is_gen, is_err_lvl, is_dbg;
  logic [31:0] base, offset, ret_pc;

  assign is_gen     = (kind_i <= K_LAST_LOW) || (kind_i == K_FPE) || (kind_i == K_CACHE);
  assign is_err_lvl = (kind_i == K_NMI) || (kind_i == K_SRST);
  assign is_dbg     = (kind_i == K_DBG);
  assign base       = bev_i ? BEV_BASE : {ebase_i[31:BASE_ALIGN], {BASE_ALIGN{1'b0}}};
  assign ret_pc     = dslot_i ? (pc_i - 32'd4) : pc_i;

  always_comb begin
    offset = OFF_GEN;
    if (kind_i == K_INT && iv_i)
      offset = OFF_IRQ;
    else if ((kind_i == K_TLBL || kind_i == K_TLBS) && refill_i && !exl_i)
      offset = OFF_REFL;
    else if (kind_i == K_CACHE)
      offset = bev_i ? OFF_CBEV : OFF_CNORM;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_o      <= BOOT_VEC;
      exl_o     <= 1'b0;
      erl_o     <= 1'b1;
      bev_o     <= 1'b1;
      ksu_o     <= 2'd0;
      bd_o      <= 1'b0;
      exccode_o <= 5'd0;
      ce_o      <= 2'd0;
      epc_o     <= 32'd0;
      errepc_o  <= 32'd0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (req_i) begin
        if (is_gen || is_err_lvl || is_dbg) begin
          done_o    <= 1'b1;
          exl_o     <= exl_i;
          erl_o     <= erl_i;
          bev_o     <= bev_i;
          ksu_o     <= ksu_i;
          bd_o      <= bd_i;
          exccode_o <= exccode_i;
          ce_o      <= ce_i;
          epc_o     <= epc_i;
          errepc_o  <= errepc_i;
        end else begin
          err_o <= 1'b1;
        end
        if (is_gen) begin
          pc_o      <= base + offset;
          exccode_o <= kind_i;
          exl_o     <= 1'b1;
          if (kind_i == K_COPU) ce_o <= cop_i;
          if (!exl_i) begin
            epc_o <= ret_pc;
            bd_o  <= dslot_i;
            ksu_o <= 2'd0;
          end
        end else if (is_err_lvl) begin
          pc_o     <= BOOT_VEC;
          errepc_o <= ret_pc;
          erl_o    <= 1'b1;
          bev_o    <= 1'b1;
          ksu_o    <= 2'd0;
        end else if (is_dbg) begin
          pc_o  <= DEBUG_VEC;
          ksu_o <= 2'd0;
        end
      end
    end
  end
endmodule

// File: rtl/exc_vector_chk.sv
module exc_vector_chk #(
  parameter logic [31:0] BOOT_VEC  = 32'hBFC00000,
  parameter logic [31:0] DEBUG_VEC = 32'hBFC00480
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_i,
  input logic [4:0]  kind_i,
  input logic [31:0] pc_i,
  input logic        dslot_i,
  input logic        exl_i,
  input logic [31:0] pc_o,
  input logic        exl_o,
  input logic        erl_o,
  input logic        bev_o,
  input logic [1:0]  ksu_o,
  input logic [31:0] epc_o,
  input logic        done_o,
  input logic        err_o
);
  // R11
  done_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o) |-> $past(req_i));

  // R12
  excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  // R12
  unknown_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ($stable(pc_o) && $stable(epc_o) && $stable(ksu_o)));

  // R7
  first_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !$past(exl_i) &&
     ($past(kind_i) <= 5'd13 || $past(kind_i) == 5'd15 || $past(kind_i) == 5'd30))
    |-> (exl_o && ksu_o == 2'd0 &&
         epc_o == ($past(dslot_i) ? $past(pc_i) - 32'd4 : $past(pc_i))));

  // R9
  err_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && ($past(kind_i) == 5'd16 || $past(kind_i) == 5'd17))
    |-> (erl_o && bev_o && pc_o == BOOT_VEC));

  // R10
  debug_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(kind_i) == 5'd19) |-> (pc_o == DEBUG_VEC && ksu_o == 2'd0));
endmodule

bind exc_vector_unit exc_vector_chk #(.BOOT_VEC(BOOT_VEC), .DEBUG_VEC(DEBUG_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .kind_i(kind_i), .pc_i(pc_i),
  .dslot_i(dslot_i), .exl_i(exl_i), .pc_o(pc_o), .exl_o(exl_o), .erl_o(erl_o),
  .bev_o(bev_o), .ksu_o(ksu_o), .epc_o(epc_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/tb_exc_vector_unit.sv
module tb_exc_vector_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_i = 0, dslot_i = 0, refill_i = 0, exl_i = 0, erl_i = 0, bev_i = 0, iv_i = 0, bd_i = 0;
  logic [4:0]  kind_i = 0, exccode_i = 0;
  logic [1:0]  cop_i = 0, ksu_i = 0, ce_i = 0;
  logic [31:0] pc_i = 0, epc_i = 0, errepc_i = 0, ebase_i = 0;
  logic [31:0] pc_o, epc_o, errepc_o;
  logic        exl_o, erl_o, bev_o, bd_o, done_o, err_o;
  logic [1:0]  ksu_o, ce_o;
  logic [4:0]  exccode_o;

  exc_vector_unit dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .kind_i(kind_i), .pc_i(pc_i),
    .dslot_i(dslot_i), .refill_i(refill_i), .cop_i(cop_i), .exl_i(exl_i),
    .erl_i(erl_i), .bev_i(bev_i), .iv_i(iv_i), .ksu_i(ksu_i), .bd_i(bd_i),
    .exccode_i(exccode_i), .ce_i(ce_i), .epc_i(epc_i), .errepc_i(errepc_i),
    .ebase_i(ebase_i), .pc_o(pc_o), .exl_o(exl_o), .erl_o(erl_o), .bev_o(bev_o),
    .ksu_o(ksu_o), .bd_o(bd_o), .exccode_o(exccode_o), .ce_o(ce_o),
    .epc_o(epc_o), .errepc_o(errepc_o), .done_o(done_o), .err_o(err_o)
  );

  int vectors = 0, fails = 0;
  logic [31:0] e_pc = 32'hBFC00000, e_epc = 0, e_errepc = 0;
  logic e_exl = 0, e_erl = 1, e_bev = 1, e_bd = 0, e_done = 0, e_err = 0;
  logic [1:0] e_ksu = 0, e_ce = 0;
  logic [4:0] e_code = 0;
  string t_pc = "R1", t_gen = "R1", t_code = "R1", t_ce = "R1", t_err = "R1";

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic compare_all();
    chk(t_pc, "pc", pc_o, e_pc);
    chk(t_gen, "epc", epc_o, e_epc);
    chk(t_gen, "bd", {31'd0, bd_o}, {31'd0, e_bd});
    chk(t_gen, "exl", {31'd0, exl_o}, {31'd0, e_exl});
    chk(t_gen, "ksu", {30'd0, ksu_o}, {30'd0, e_ksu});
    chk(t_err, "errepc", errepc_o, e_errepc);
    chk(t_err, "erl", {31'd0, erl_o}, {31'd0, e_erl});
    chk(t_err, "bev", {31'd0, bev_o}, {31'd0, e_bev});
    chk(t_code, "exccode", {27'd0, exccode_o}, {27'd0, e_code});
    chk(t_ce, "ce", {30'd0, ce_o}, {30'd0, e_ce});
    chk("R11", "done", {31'd0, done_o}, {31'd0, e_done});
    chk("R12", "err", {31'd0, err_o}, {31'd0, e_err});
  endtask

  // Behavioural reference: predicts the outputs after the coming edge.
  task automatic predict();
    logic [31:0] saved;
    logic ordinary;
    e_done = 0; e_err = 0;
    if (!req_i) begin
      t_pc = "R11"; t_gen = "R11"; t_code = "R11"; t_ce = "R11"; t_err = "R11";
      return;
    end
    saved = dslot_i ? pc_i - 4 : pc_i;
    ordinary = (kind_i inside {[5'd0:5'd13]}) || kind_i == 5'd15 || kind_i == 5'd30;
    if (!(ordinary || kind_i == 5'd16 || kind_i == 5'd17 || kind_i == 5'd19)) begin
      e_err = 1;
      t_pc = "R12"; t_gen = "R12"; t_code = "R12"; t_ce = "R12"; t_err = "R12";
      return;
    end
    e_done = 1;
    e_exl = exl_i; e_erl = erl_i; e_bev = bev_i; e_ksu = ksu_i; e_bd = bd_i;
    e_code = exccode_i; e_ce = ce_i; e_epc = epc_i; e_errepc = errepc_i;
    if (kind_i == 5'd19) begin
      e_pc = 32'hBFC00480; e_ksu = 0;
      t_pc = "R10"; t_gen = "R10"; t_code = "R10"; t_ce = "R10"; t_err = "R10";
    end else if (kind_i == 5'd16 || kind_i == 5'd17) begin
      e_pc = 32'hBFC00000; e_errepc = saved; e_erl = 1; e_bev = 1; e_ksu = 0;
      t_pc = "R9"; t_gen = "R9"; t_code = "R9"; t_ce = "R9"; t_err = "R9";
    end else begin
      logic [31:0] vb, off;
      vb = bev_i ? 32'hBFC00200 : (ebase_i & 32'hFFFF_FC00);
      off = 32'h180;
      t_pc = bev_i ? "R3" : "R2";
      if (kind_i == 0 && iv_i) begin off = 32'h200; t_pc = "R3"; end
      if ((kind_i == 2 || kind_i == 3) && refill_i) begin
        t_pc = "R4";
        if (!exl_i) off = 0;
      end
      if (kind_i == 30) begin off = bev_i ? 32'h100 : 32'h2000_0100; t_pc = "R5"; end
      e_pc = vb + off;
      e_code = kind_i; t_code = "R6";
      t_ce = "R8";
      if (kind_i == 11) e_ce = cop_i;
      t_gen = "R7"; t_err = "R7";
      e_exl = 1;
      if (!exl_i) begin e_epc = saved; e_bd = dslot_i; e_ksu = 0; end
    end
  endtask

  task automatic step();
    predict();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    req_i = 0;
  endtask

  task automatic fire(input logic [4:0] k, input logic [31:0] pc, input logic ds, input logic rf,
                      input logic exl, input logic bev, input logic iv);
    req_i = 1; kind_i = k; pc_i = pc; dslot_i = ds; refill_i = rf;
    exl_i = exl; bev_i = bev; iv_i = iv;
    step();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_all();                      // R1 during reset
    rst_n = 1;
    @(negedge clk);
    compare_all();                      // R1 after release
    ebase_i = 32'h8000_13FF; epc_i = 32'h1111_0000; errepc_i = 32'h2222_0000;
    ksu_i = 2'd2; bd_i = 1; exccode_i = 5'd9; ce_i = 2'd1; cop_i = 2'd3; erl_i = 0;
    fire(5'd8,  32'h0040_0100, 0, 0, 0, 0, 0);   // R2 R6 R7
    fire(5'd8,  32'h0040_0100, 0, 0, 0, 1, 0);   // R3 bev base
    fire(5'd0,  32'h0040_0200, 1, 0, 0, 0, 1);   // R3 interrupt IV, R7 delay slot
    fire(5'd0,  32'h0040_0200, 0, 0, 0, 0, 0);   // R3 interrupt without IV
    fire(5'd2,  32'h0040_0300, 0, 1, 0, 0, 0);   // R4 refill load
    fire(5'd3,  32'h0040_0304, 1, 1, 1, 0, 0);   // R4 refill while EXL set, R7 hold
    fire(5'd3,  32'h0040_0308, 0, 1, 0, 1, 0);   // R4 refill store at bev base
    fire(5'd30, 32'h0040_0400, 0, 0, 0, 1, 0);   // R5 bev
    fire(5'd30, 32'h0040_0400, 0, 0, 0, 0, 0);   // R5 normal
    fire(5'd11, 32'h0040_0500, 0, 0, 0, 0, 0);   // R8
    fire(5'd12, 32'h0040_0504, 0, 0, 0, 0, 0);   // R8 passthrough
    fire(5'd16, 32'h0040_0600, 1, 0, 1, 0, 0);   // R9 nmi
    fire(5'd17, 32'h0040_0700, 0, 0, 0, 0, 0);   // R9 soft reset
    fire(5'd19, 32'h0040_0800, 0, 0, 0, 0, 0);   // R10
    step(); step();                              // R11 idle hold
    fire(5'd14, 32'h0040_0900, 0, 0, 0, 0, 0);   // R12
    fire(5'd18, 32'h0040_0904, 0, 0, 0, 0, 0);   // R12
    fire(5'd31, 32'h0040_0908, 1, 0, 0, 0, 0);   // R12
    for (int i = 0; i < 3000; i++) begin
      req_i = $urandom_range(0, 3) != 0;
      kind_i = 5'($urandom); pc_i = $urandom & 32'hFFFF_FFFC;
      dslot_i = 1'($urandom); refill_i = 1'($urandom); cop_i = 2'($urandom);
      exl_i = 1'($urandom); erl_i = 1'($urandom); bev_i = 1'($urandom);
      iv_i = 1'($urandom); ksu_i = 2'($urandom); bd_i = 1'($urandom);
      exccode_i = 5'($urandom); ce_i = 2'($urandom); epc_i = $urandom;
      errepc_i = $urandom; ebase_i = $urandom;
      step();
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule